// File: doc/BRIEF.md
# DS3 C-Bit Overhead Generator

This block supplies the value of every C-bit overhead position in a DS3 M-frame sent in C-bit parity mode. An external M-frame counter pulses a slot strobe whenever a C-bit position comes up, giving the M-subframe number (1 to 7) and the bit number within that subframe (1 to 3). Subframe k carries C-bits 3k-2, 3k-1 and 3k, so the pair maps onto C1 to C21. One clock after each strobe the block presents the bit to send.

Per-frame context is captured on the C1 strobe, which marks the frame boundary. This context is the payload parity of the previous frame, the receive-side error flags (C-bit parity error and framing error) and the software override request. It is held for the rest of the frame. The far-end alarm bit from a control register is sampled live at its own slot.

Maintenance data-link bits enter through a valid/ready stream. The block raises `dl_ready` only during the strobe cycle of a data-link slot, and a bit moves when `dl_valid` and `dl_ready` are both high. An upstream source that is not ready is never waited for: the slot is filled with 1 and the frame carries on. The output `cbit_valid` is a one-cycle pulse with no back-pressure, because the line timing is fixed by the frame counter.

Top module: `ds3_cbit_gen`

## Requirements
- R1: `cbit_valid` is high in exactly the cycle after each cycle in which `slot_strobe` is high, and is low otherwise.
- R2: With no override, C1 (subframe 1, bit 1, the mode identification bit) and C2 (the reserved bit) are sent as 1. The undefined positions C4, C5, C6 and C16 to C21 are also sent as 1.
- R3: With no override, C3 sends the value of `alarm_bit` sampled in the strobe cycle of that slot.
- R4: With no override, C7, C8 and C9 all send the `frame_parity` value sampled at the C1 strobe of the same frame. Later changes of `frame_parity` within the frame have no effect.
- R5: If `rx_cp_err` or `rx_frm_err` is high at the C1 strobe, C10 to C12 send 0 for the whole frame. If neither is high, they send 1. Error flags that change after C1 do not change the frame's value.
- R6: For C13 to C15 with `dl_en` high and no override, `dl_ready` is high in the strobe cycle. If `dl_valid` is also high, `dl_data` is sent. If `dl_valid` is low, 1 is sent. With `dl_en` low, `dl_ready` stays low and 1 is sent. `dl_ready` is never high outside a strobe cycle.
- R7: `ovr_mode` is sampled only at the C1 strobe and holds for the whole frame. The encodings are 0 for normal, 1 for AIS (every C-bit sent as 0), 2 for idle (every C-bit sent as 1) and 3, which is treated as normal. While an override is active, `dl_ready` stays low.
- R8: A strobe with subframe 0, subframe above 7, or bit index 0 sends 1. It captures nothing and keeps `dl_ready` low.
- R9: Reset clears `cbit_valid`, sets `cbit_data` to 1, and sets the held context to parity 0, no far-end error and normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_strobe | input | 1 | A C-bit position is due this cycle |
| slot_sf | input | 3 | M-subframe number, 1 to 7 |
| slot_idx | input | 2 | Bit within subframe, 1 to 3 |
| frame_parity | input | 1 | Parity of the previous frame's payload |
| rx_cp_err | input | 1 | Receive C-bit parity error flag |
| rx_frm_err | input | 1 | Receive framing error flag |
| alarm_bit | input | 1 | Far-end alarm channel bit from a control register |
| ovr_mode | input | 2 | Override request: 0 normal, 1 AIS, 2 idle, 3 normal |
| dl_en | input | 1 | Take data-link slots from the stream input |
| dl_valid | input | 1 | Data-link bit available |
| dl_data | input | 1 | Data-link bit |
| dl_ready | output | 1 | Data-link bit accepted this cycle if valid |
| cbit_valid | output | 1 | Output bit valid pulse |
| cbit_data | output | 1 | C-bit value to transmit |

## Verification
A wrong held context shows up as a wrong value at the next parity, far-end error or AIS slot of the same frame, which is at most eleven strobes after C1. A wrongly timed capture shows up only when an input changes in the middle of a frame. The bench therefore changes parity, error flags and override requests between slots and checks that the effect appears only after the next C1 strobe. A handshake fault shows up in the same strobe cycle as `dl_ready` asserted at the wrong time, and on the next cycle as a data-link bit that does not match what the source offered.

// File: rtl/ds3_cbit_pkg.sv
`timescale 1ns/1ps
package ds3_cbit_pkg;

  // Slot positions (1-based C-bit numbers); the line order depends on them.
  localparam int ALARM_SLOT = 3;
  localparam int PAR_FIRST  = 7;
  localparam int FE_FIRST   = 10;
  localparam int DL_FIRST   = 13;
  localparam int GROUP_LEN  = 3;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_AIS  = 2'd1,
    OVR_IDLE = 2'd2,
    OVR_RSVD = 2'd3
  } ovr_e;

  typedef enum logic [2:0] {
    FN_ONE   = 3'd0,
    FN_ALARM = 3'd1,
    FN_PAR   = 3'd2,
    FN_FE    = 3'd3,
    FN_DL    = 3'd4
  } slot_fn_e;

  function automatic slot_fn_e slot_fn(input int n);
    if (n == ALARM_SLOT)                               return FN_ALARM;
    else if (n >= PAR_FIRST && n < PAR_FIRST + GROUP_LEN) return FN_PAR;
    else if (n >= FE_FIRST  && n < FE_FIRST  + GROUP_LEN) return FN_FE;
    else if (n >= DL_FIRST  && n < DL_FIRST  + GROUP_LEN) return FN_DL;
    else                                               return FN_ONE;
  endfunction

endpackage

// File: rtl/cbit_slot_decode.sv
`timescale 1ns/1ps
module cbit_slot_decode
  import ds3_cbit_pkg::*;
#(
  parameter int NUM_SF      = 7,
  parameter int BITS_PER_SF = 3,
  parameter int SF_W        = 3,
  parameter int IDX_W       = 2,
  parameter int SLOT_W      = 5
) (
  input  logic [SF_W-1:0]   sf,
  input  logic [IDX_W-1:0]  idx,
  output logic              in_range,
  output logic              first_slot,
  output logic [SLOT_W-1:0] slot_num,
  output slot_fn_e          fn
);

  always_comb begin
    in_range   = (sf != '0) && (int'(sf) <= NUM_SF) &&
                 (idx != '0) && (int'(idx) <= BITS_PER_SF);
    slot_num   = in_range ? SLOT_W'((int'(sf) - 1) * BITS_PER_SF + int'(idx))
                          : '0;
    first_slot = in_range && (slot_num == SLOT_W'(1));
    fn         = in_range ? slot_fn(int'(slot_num)) : FN_ONE;
  end

endmodule

// File: rtl/cbit_frame_state.sv
`timescale 1ns/1ps
module cbit_frame_state
  import ds3_cbit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic err_cp,
  input  logic err_frm,
  input  logic par_in,
  input  ovr_e ovr_in,
  output logic fe_eff,
  output logic par_eff,
  output ovr_e ovr_eff,
  output logic par_q,
  output ovr_e ovr_q
);

  logic fe_q;
  ovr_e ovr_clean;

  always_comb begin
    ovr_clean = (ovr_in == OVR_RSVD) ? OVR_NONE : ovr_in;
    fe_eff    = capture ? (err_cp | err_frm) : fe_q;
    par_eff   = capture ? par_in : par_q;
    ovr_eff   = capture ? ovr_clean : ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= 1'b0;
      par_q <= 1'b0;
      ovr_q <= OVR_NONE;
    end else if (capture) begin
      fe_q  <= err_cp | err_frm;
      par_q <= par_in;
      ovr_q <= ovr_clean;
    end
  end

endmodule

// File: rtl/cbit_dl_port.sv
`timescale 1ns/1ps
module cbit_dl_port (
  input  logic dl_slot,
  input  logic dl_en,
  input  logic normal_mode,
  input  logic dl_valid,
  input  logic dl_data,
  output logic dl_ready,
  output logic dl_bit
);

  always_comb begin
    dl_ready = dl_slot & dl_en & normal_mode;
    dl_bit   = (dl_ready & dl_valid) ? dl_data : 1'b1;
  end

endmodule

// File: rtl/ds3_cbit_gen.sv
`timescale 1ns/1ps
module ds3_cbit_gen
  import ds3_cbit_pkg::*;
#(
  parameter int NUM_SF      = 7,
  parameter int BITS_PER_SF = 3,
  localparam int SF_W       = $clog2(NUM_SF + 1),
  localparam int IDX_W      = $clog2(BITS_PER_SF + 1),
  localparam int SLOT_W     = $clog2(NUM_SF * BITS_PER_SF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_strobe,
  input  logic [SF_W-1:0]  slot_sf,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic             frame_parity,
  input  logic             rx_cp_err,
  input  logic             rx_frm_err,
  input  logic             alarm_bit,
  input  logic [1:0]       ovr_mode,
  input  logic             dl_en,
  input  logic             dl_valid,
  input  logic             dl_data,
  output logic             dl_ready,
  output logic             cbit_valid,
  output logic             cbit_data
);

  logic              in_range;
  logic              first_slot;
  logic [SLOT_W-1:0] slot_num;
  slot_fn_e          fn;
  logic              fe_eff, par_eff, par_q;
  ovr_e              ovr_eff, ovr_q;
  logic              dl_bit;
  logic              next_bit;
  logic [1:0]        ovr_held;
  logic              par_held;

  cbit_slot_decode #(
    .NUM_SF(NUM_SF), .BITS_PER_SF(BITS_PER_SF),
    .SF_W(SF_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_dec (
    .sf(slot_sf), .idx(slot_idx), .in_range(in_range),
    .first_slot(first_slot), .slot_num(slot_num), .fn(fn)
  );

  cbit_frame_state u_state (
    .clk(clk), .rst_n(rst_n),
    .capture(slot_strobe & first_slot),
    .err_cp(rx_cp_err), .err_frm(rx_frm_err),
    .par_in(frame_parity), .ovr_in(ovr_e'(ovr_mode)),
    .fe_eff(fe_eff), .par_eff(par_eff), .ovr_eff(ovr_eff),
    .par_q(par_q), .ovr_q(ovr_q)
  );

  cbit_dl_port u_dl (
    .dl_slot(slot_strobe & (fn == FN_DL)),
    .dl_en(dl_en), .normal_mode(ovr_eff == OVR_NONE),
    .dl_valid(dl_valid), .dl_data(dl_data),
    .dl_ready(dl_ready), .dl_bit(dl_bit)
  );

  assign ovr_held = ovr_q;
  assign par_held = par_q;

  always_comb begin
    if (!in_range) begin
      next_bit = 1'b1;
    end else begin
      unique case (ovr_eff)
        OVR_AIS:  next_bit = 1'b0;
        OVR_IDLE: next_bit = 1'b1;
        default: begin
          unique case (fn)
            FN_ALARM: next_bit = alarm_bit;
            FN_PAR:   next_bit = par_eff;
            FN_FE:    next_bit = ~fe_eff;
            FN_DL:    next_bit = dl_bit;
            default:  next_bit = 1'b1;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cbit_valid <= 1'b0;
      cbit_data  <= 1'b1;
    end else begin
      cbit_valid <= slot_strobe;
      if (slot_strobe) cbit_data <= next_bit;
    end
  end

endmodule

// File: rtl/cbit_gen_chk.sv
`timescale 1ns/1ps
module cbit_gen_chk #(
  parameter int SF_W  = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_strobe,
  input logic [SF_W-1:0]  slot_sf,
  input logic [IDX_W-1:0] slot_idx,
  input logic             dl_ready,
  input logic             dl_valid,
  input logic             dl_data,
  input logic             cbit_valid,
  input logic             cbit_data,
  input logic [1:0]       ovr_held,
  input logic             par_held
);

  logic is_first;
  logic is_valid_pos;
  assign is_first     = (slot_sf == SF_W'(1)) && (slot_idx == IDX_W'(1));
  assign is_valid_pos = (slot_sf != '0) && (int'(slot_sf) <= 7) &&
                        (slot_idx != '0) && (int'(slot_idx) <= 3);

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_strobe |=> cbit_valid);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_strobe |=> !cbit_valid);

  // R6
  ready_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_ready |-> slot_strobe);

  // R6
  dl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_ready && dl_valid) |=> (cbit_data == $past(dl_data)));

  // R7
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(slot_strobe && is_first) |=> $stable(ovr_held));

  // R7
  ais_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && !is_first && is_valid_pos && ovr_held == 2'd1) |=> !cbit_data);

  // R4
  par_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_strobe && slot_sf == SF_W'(3) && slot_idx != '0 && ovr_held == 2'd0)
      |=> (cbit_data == $past(par_held)));

endmodule

bind ds3_cbit_gen cbit_gen_chk #(.SF_W(SF_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
  .slot_sf(slot_sf), .slot_idx(slot_idx),
  .dl_ready(dl_ready), .dl_valid(dl_valid), .dl_data(dl_data),
  .cbit_valid(cbit_valid), .cbit_data(cbit_data),
  .ovr_held(ovr_held), .par_held(par_held)
);

// File: tb/ds3_cbit_gen_bench.sv
`timescale 1ns/1ps
module ds3_cbit_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_strobe = 1'b0;
  logic [2:0] slot_sf = '0;
  logic [1:0] slot_idx = '0;
  logic       frame_parity = 1'b0;
  logic       rx_cp_err = 1'b0;
  logic       rx_frm_err = 1'b0;
  logic       alarm_bit = 1'b0;
  logic [1:0] ovr_mode = 2'd0;
  logic       dl_en = 1'b0;
  logic       dl_valid = 1'b0;
  logic       dl_data = 1'b0;
  logic       dl_ready;
  logic       cbit_valid;
  logic       cbit_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic got_valid, got_data, got_ready;

  always #2.5 clk = ~clk;

  ds3_cbit_gen u_ds3_cbit_gen (
    .clk(clk), .rst_n(rst_n), .slot_strobe(slot_strobe),
    .slot_sf(slot_sf), .slot_idx(slot_idx), .frame_parity(frame_parity),
    .rx_cp_err(rx_cp_err), .rx_frm_err(rx_frm_err), .alarm_bit(alarm_bit),
    .ovr_mode(ovr_mode), .dl_en(dl_en), .dl_valid(dl_valid),
    .dl_data(dl_data), .dl_ready(dl_ready),
    .cbit_valid(cbit_valid), .cbit_data(cbit_data)
  );

  // {subframe, index, expected}: errors flagged, parity 0, alarm 0, link off
  localparam logic [5:0] FRAME_A [21] = '{
    {3'd1, 2'd1, 1'b1}, {3'd1, 2'd2, 1'b1}, {3'd1, 2'd3, 1'b0},
    {3'd2, 2'd1, 1'b1}, {3'd2, 2'd2, 1'b1}, {3'd2, 2'd3, 1'b1},
    {3'd3, 2'd1, 1'b0}, {3'd3, 2'd2, 1'b0}, {3'd3, 2'd3, 1'b0},
    {3'd4, 2'd1, 1'b0}, {3'd4, 2'd2, 1'b0}, {3'd4, 2'd3, 1'b0},
    {3'd5, 2'd1, 1'b1}, {3'd5, 2'd2, 1'b1}, {3'd5, 2'd3, 1'b1},
    {3'd6, 2'd1, 1'b1}, {3'd6, 2'd2, 1'b1}, {3'd6, 2'd3, 1'b1},
    {3'd7, 2'd1, 1'b1}, {3'd7, 2'd2, 1'b1}, {3'd7, 2'd3, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_slot(input logic [2:0] sf, input logic [1:0] idx);
    @(negedge clk);
    slot_sf = sf; slot_idx = idx; slot_strobe = 1'b1;
    #1 got_ready = dl_ready;
    @(negedge clk);
    got_valid = cbit_valid;
    got_data  = cbit_data;
    slot_strobe = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 valid in reset", cbit_valid, 1'b0);
    check("R9 data in reset", cbit_data, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 no valid without strobe", cbit_valid, 1'b0);

    // Frame A by table: R2 R3 R4 R5 R6
    rx_cp_err = 1'b1;
    for (int i = 0; i < 21; i++) begin
      do_slot(FRAME_A[i][5:3], FRAME_A[i][2:1]);
      check("R1 valid after strobe", got_valid, 1'b1);
      check("R2/R3/R4/R5 frame A bit", got_data, FRAME_A[i][0]);
      check("R6 ready low with link off", got_ready, 1'b0);
    end

    // Frame B: no errors, parity 1, alarm 1, link on
    rx_cp_err = 1'b0; frame_parity = 1'b1; alarm_bit = 1'b1; dl_en = 1'b1;
    do_slot(3'd1, 2'd1);
    check("R2 C1 one", got_data, 1'b1);
    rx_cp_err = 1'b1; frame_parity = 1'b0;
    do_slot(3'd1, 2'd3);
    check("R3 alarm 1", got_data, 1'b1);
    alarm_bit = 1'b0;
    do_slot(3'd1, 2'd3);
    check("R3 alarm live 0", got_data, 1'b0);
    for (int k = 1; k <= 3; k++) begin
      do_slot(3'd3, 2'(k));
      check("R4 parity held", got_data, 1'b1);
    end
    for (int k = 1; k <= 3; k++) begin
      do_slot(3'd4, 2'(k));
      check("R5 no error held", got_data, 1'b1);
    end
    @(negedge clk);
    check("R1 idle cycle", cbit_valid, 1'b0);
    dl_valid = 1'b1; dl_data = 1'b0;
    do_slot(3'd5, 2'd1);
    dl_valid = 1'b0;
    check("R6 ready on link slot", got_ready, 1'b1);
    check("R6 link bit sent", got_data, 1'b0);
    do_slot(3'd5, 2'd2);
    check("R6 ready without valid", got_ready, 1'b1);
    check("R6 fill when not valid", got_data, 1'b1);
    dl_valid = 1'b1; dl_data = 1'b0;
    do_slot(3'd5, 2'd3);
    dl_valid = 1'b0;
    check("R6 link bit sent 2", got_data, 1'b0);
    ovr_mode = 2'd1;
    do_slot(3'd6, 2'd1);
    check("R7 AIS deferred", got_data, 1'b1);
    do_slot(3'd7, 2'd3);
    check("R7 AIS deferred end", got_data, 1'b1);

    // Frame C: AIS
    rx_cp_err = 1'b0;
    do_slot(3'd1, 2'd1);
    check("R7 AIS C1", got_data, 1'b0);
    dl_valid = 1'b1; dl_data = 1'b0;
    do_slot(3'd5, 2'd1);
    check("R7 AIS link ready low", got_ready, 1'b0);
    check("R7 AIS link slot", got_data, 1'b0);
    dl_valid = 1'b0;
    do_slot(3'd0, 2'd1);
    check("R8 subframe 0 ones", got_data, 1'b1);
    check("R8 ready low", got_ready, 1'b0);
    do_slot(3'd3, 2'd0);
    check("R8 index 0 ones", got_data, 1'b1);
    ovr_mode = 2'd2;
    do_slot(3'd4, 2'd1);
    check("R7 idle deferred", got_data, 1'b0);

    // Frame D: idle
    frame_parity = 1'b0; alarm_bit = 1'b0;
    do_slot(3'd1, 2'd3);
    check("R8 first slot only at C1", got_data, 1'b0);
    do_slot(3'd1, 2'd1);
    check("R7 idle C1", got_data, 1'b1);
    do_slot(3'd1, 2'd3);
    check("R7 idle alarm slot", got_data, 1'b1);
    do_slot(3'd3, 2'd1);
    check("R7 idle parity slot", got_data, 1'b1);
    do_slot(3'd5, 2'd1);
    check("R7 idle ready low", got_ready, 1'b0);

    // Frame E: code 3 acts as normal, framing error alone
    ovr_mode = 2'd3; rx_frm_err = 1'b1;
    do_slot(3'd1, 2'd1);
    check("R7 code3 C1", got_data, 1'b1);
    do_slot(3'd1, 2'd3);
    check("R7 code3 normal alarm", got_data, 1'b0);
    do_slot(3'd4, 2'd2);
    check("R5 framing error", got_data, 1'b0);

    // Reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 valid after reset", cbit_valid, 1'b0);
    check("R9 data after reset", cbit_data, 1'b1);
    rst_n = 1'b1; ovr_mode = 2'd1; frame_parity = 1'b1;
    do_slot(3'd3, 2'd1);
    check("R9 parity cleared", got_data, 1'b0);
    do_slot(3'd4, 2'd1);
    check("R9 far-end error cleared", got_data, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule